// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Divider

This block is the feedback divider of a frequency synthesizer loop. It divides its input clock by N = B·P + A. A prescaler counts either P+1 or P input clocks per prescaler cycle. A swallow counter (A) and a main counter (B), both advanced once per prescaler cycle, steer it. Each divide period begins with A prescaler cycles of length P+1, followed by B−A cycles of length P.

New settings enter a staging register when the load strobe is high. The divider picks them up only at the next period boundary, so a period in progress always completes with the ratio it started with. The same edge that ends a period reloads both counters and starts the next one. One single-clock output pulse therefore marks every N input clocks, with no idle clocks between periods. A configuration flag reports staged settings for which the ratio is not guaranteed.

Top module: `pulse_swallow_div`

## Requirements
- R1: After reset, div_pulse and cfg_err are 0. The divider runs with the reset configuration: select 0, A = 0, B = 3, giving a period of 24 input clocks.
- R2: With settings staged and applied, the distance between successive div_pulse assertions is B·P + A input clocks. The lower modulus P follows the 2-bit select: 0 gives 8, 1 gives 16, 2 gives 32 and 3 gives 64.
- R3: div_pulse is high for exactly one input clock per period.
- R4: The ratio holds at the swallow boundaries A = 0 (all cycles of length P) and A = B (all cycles of length P+1, N = B·(P+1)), up to A = 63.
- R5: Changes on psel, a_val and b_val while load is low have no effect on the period or on cfg_err.
- R6: Settings staged during a period take effect only at the next period boundary. The period in progress keeps its old length.
- R7: Consecutive periods with unchanged settings have equal length, with no gap clocks between them.
- R8: One clock after a load, cfg_err is 1 if the staged B is below the staged A or below 3, and 0 otherwise. It changes only after a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Strobe that captures psel, a_val and b_val into the staging register |
| psel | input | 2 | Prescaler select: 0→8/9, 1→16/17, 2→32/33, 3→64/65 |
| a_val | input | 6 | Swallow count A |
| b_val | input | 13 | Main count B |
| div_pulse | output | 1 | One-clock pulse per divide period |
| cfg_err | output | 1 | Staged settings violate B ≥ A or B ≥ 3 |

## Verification
The bench uses the default parameters: select 0 with A = 0 and B = 3 out of reset, 6-bit A and 13-bit B. This makes every modulus pair reachable within a few thousand clocks, including the A = 63 swallow limit at P = 32 and long periods at P = 64. Counting clocks between pulses covers both edges of the swallow range. A load issued in the middle of a period shows the deferred application directly at the output. Loads of small or inverted B values drive the error flag.

// File: rtl/psd_pkg.sv
package psd_pkg;
    localparam int A_W  = 6;
    localparam int B_W  = 13;
    localparam int PC_W = 7;
    localparam int B_MIN = 3;

    typedef logic [1:0] psel_t;

    typedef struct packed {
        psel_t          psel;
        logic [A_W-1:0] a;
        logic [B_W-1:0] b;
    } cfg_t;

    function automatic logic [PC_W-1:0] low_modulus(input psel_t s);
        return PC_W'(8) << s;
    endfunction
endpackage

// File: rtl/psd_cfg_stage.sv
module psd_cfg_stage
    import psd_pkg::*;
#(
    parameter cfg_t RST_CFG = '{psel: 2'd0, a: '0, b: B_W'(3)}
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  psel_t          psel_in,
    input  logic [A_W-1:0] a_in,
    input  logic [B_W-1:0] b_in,
    output cfg_t           cfg,
    output logic           err
);
    localparam int PAD_W = B_W - A_W;

    cfg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.psel = psel_in;
            st_d.a    = a_in;
            st_d.b    = b_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RST_CFG;
        else        st_q <= st_d;
    end

    assign cfg = st_q;
    assign err = (st_q.b < {{PAD_W{1'b0}}, st_q.a}) || (st_q.b < B_W'(B_MIN));
endmodule

// File: rtl/psd_prescaler.sv
module psd_prescaler
    import psd_pkg::*;
#(
    parameter logic [PC_W-1:0] RST_PC = PC_W'(7)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] p_next,
    input  logic            plus1,
    output logic            tc
);
    typedef struct packed {
        logic [PC_W-1:0] pc;
    } pre_t;

    pre_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.pc == '0) begin
            // modulus of the next prescaler cycle: P+1 counts P..0, P counts P-1..0
            s_d.pc = plus1 ? p_next : p_next - PC_W'(1);
        end else begin
            s_d.pc = s_q.pc - PC_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q.pc <= RST_PC;
        else        s_q    <= s_d;
    end

    assign tc = (s_q.pc == '0);
endmodule

// File: rtl/psd_counters.sv
module psd_counters
    import psd_pkg::*;
#(
    parameter logic [A_W-1:0] RST_A    = '0,
    parameter logic [B_W-1:0] RST_B    = B_W'(3),
    parameter psel_t          RST_PSEL = 2'd0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tc,
    input  cfg_t            cfg,
    output logic [PC_W-1:0] p_next,
    output logic [PC_W-1:0] p_act,
    output logic            plus1,
    output logic            pulse
);
    typedef struct packed {
        logic [A_W-1:0]  a;
        logic [B_W-1:0]  b;
        logic [PC_W-1:0] p;
        logic            pulse;
    } cnt_t;

    cnt_t            s_d, s_q;
    logic [A_W-1:0]  a_after;
    logic [B_W-1:0]  b_after;
    logic            last;

    always_comb begin
        s_d     = s_q;
        a_after = (s_q.a != '0) ? s_q.a - A_W'(1) : '0;
        b_after = s_q.b - B_W'(1);
        last    = tc && (b_after == '0);
        plus1   = 1'b0;
        s_d.pulse = last;
        if (tc) begin
            if (last) begin
                s_d.a = cfg.a;
                s_d.b = cfg.b;
                s_d.p = low_modulus(cfg.psel);
                plus1 = (cfg.a != '0);
            end else begin
                s_d.a = a_after;
                s_d.b = b_after;
                plus1 = (a_after != '0);
            end
        end
        p_next = s_d.p;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.a     <= RST_A;
            s_q.b     <= RST_B;
            s_q.p     <= low_modulus(RST_PSEL);
            s_q.pulse <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign p_act = s_q.p;
    assign pulse = s_q.pulse;
endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div
    import psd_pkg::*;
#(
    parameter int RST_PSEL = 0,
    parameter int RST_A    = 0,
    parameter int RST_B    = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [1:0]     psel,
    input  logic [A_W-1:0] a_val,
    input  logic [B_W-1:0] b_val,
    output logic           div_pulse,
    output logic           cfg_err
);
    localparam psel_t           R_PSEL = psel_t'(RST_PSEL);
    localparam logic [A_W-1:0]  R_A    = A_W'(RST_A);
    localparam logic [B_W-1:0]  R_B    = B_W'(RST_B);
    localparam logic [PC_W-1:0] R_P    = low_modulus(R_PSEL);
    localparam logic [PC_W-1:0] R_PC   = (R_A != '0) ? R_P : R_P - PC_W'(1);
    localparam cfg_t            R_CFG  = '{psel: R_PSEL, a: R_A, b: R_B};

    cfg_t            cfg;
    logic            pre_tc;
    logic            plus1;
    logic [PC_W-1:0] p_next;
    logic [PC_W-1:0] p_act;

    psd_cfg_stage #(.RST_CFG(R_CFG)) stage_i (
        .clk(clk), .rst_n(rst_n), .load(load),
        .psel_in(psel), .a_in(a_val), .b_in(b_val),
        .cfg(cfg), .err(cfg_err)
    );

    psd_prescaler #(.RST_PC(R_PC)) pre_i (
        .clk(clk), .rst_n(rst_n), .p_next(p_next), .plus1(plus1), .tc(pre_tc)
    );

    psd_counters #(.RST_A(R_A), .RST_B(R_B), .RST_PSEL(R_PSEL)) cnt_i (
        .clk(clk), .rst_n(rst_n), .tc(pre_tc), .cfg(cfg),
        .p_next(p_next), .p_act(p_act), .plus1(plus1), .pulse(div_pulse)
    );
endmodule

// File: rtl/psd_chk.sv
module psd_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       load,
    input logic       tc,
    input logic       div_pulse,
    input logic       cfg_err,
    input logic [6:0] p_act
);
    // R3
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |=> !div_pulse);

    // R2
    pulse_on_tc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(div_pulse) |-> $past(tc));

    // R2
    tc_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tc |=> !tc);

    // R6
    modulus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !div_pulse |-> $stable(p_act));

    // R8
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(load) |-> $stable(cfg_err));
endmodule

bind pulse_swallow_div psd_chk chk_i (
    .clk(clk), .rst_n(rst_n), .load(load), .tc(pre_tc),
    .div_pulse(div_pulse), .cfg_err(cfg_err), .p_act(p_act)
);

// File: tb/pulse_swallow_div_tb_top.sv
module pulse_swallow_div_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load = 1'b0;
    logic [1:0]  psel = 2'd0;
    logic [5:0]  a_val = 6'd0;
    logic [12:0] b_val = 13'd3;
    logic        div_pulse;
    logic        cfg_err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    pulse_swallow_div dut_i (
        .clk(clk), .rst_n(rst_n), .load(load), .psel(psel),
        .a_val(a_val), .b_val(b_val), .div_pulse(div_pulse), .cfg_err(cfg_err)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int ratio(input int s, input int a, input int b);
        return b * (8 << s) + a;
    endfunction

    task automatic wait_pulse();
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (div_pulse) return;
        end
        check("wait_pulse", 0, 1);
    endtask

    // clocks from the current pulse to the next one; optional mid-period load
    task automatic period(output int n, input bit do_load, input int s,
                          input int a, input int b);
        n = 0;
        for (int i = 0; i < 20000; i++) begin
            if (do_load && n == 2) begin
                psel = 2'(s); a_val = 6'(a); b_val = 13'(b); load = 1'b1;
            end
            @(negedge clk);
            load = 1'b0;
            n++;
            if (div_pulse) return;
        end
    endtask

    task automatic stage(input int s, input int a, input int b);
        @(negedge clk);
        psel = 2'(s); a_val = 6'(a); b_val = 13'(b); load = 1'b1;
        @(negedge clk);
        load = 1'b0;
    endtask

    task automatic t_reset();
        int n;
        check("R1 pulse at reset", int'(div_pulse), 0);
        check("R1 err at reset", int'(cfg_err), 0);
        wait_pulse();
        period(n, 1'b0, 0, 0, 0);
        check("R1 reset period", n, 24);
    endtask

    task automatic t_ratio(input string req, input int s, input int a, input int b);
        int n1, n2;
        wait_pulse();
        stage(s, a, b);
        wait_pulse();
        @(negedge clk);
        check("R3 pulse width", int'(div_pulse), 0);
        period(n1, 1'b0, 0, 0, 0);
        n1++;
        check(req, n1, ratio(s, a, b));
        period(n2, 1'b0, 0, 0, 0);
        check("R7 back-to-back", n2, ratio(s, a, b));
    endtask

    task automatic t_defer();
        int n;
        wait_pulse();
        period(n, 1'b1, 1, 2, 4);
        check("R6 old ratio kept", n, ratio(0, 5, 7));
        period(n, 1'b0, 0, 0, 0);
        check("R6 new ratio", n, ratio(1, 2, 4));
    endtask

    task automatic t_ignore();
        int n;
        wait_pulse();
        psel = 2'd3; a_val = 6'd0; b_val = 13'd1;
        period(n, 1'b0, 0, 0, 0);
        check("R5 ignored period", n, ratio(1, 2, 4));
        period(n, 1'b0, 0, 0, 0);
        check("R5 ignored period 2", n, ratio(1, 2, 4));
        check("R5 ignored err", int'(cfg_err), 0);
    endtask

    task automatic t_err();
        stage(0, 6, 5);
        check("R8 B below A", int'(cfg_err), 1);
        stage(0, 0, 2);
        check("R8 B below 3", int'(cfg_err), 1);
        stage(0, 3, 3);
        check("R8 valid clears", int'(cfg_err), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ratio("R2 P16", 1, 3, 5);
        t_ratio("R2 P8", 0, 5, 7);
        t_ratio("R4 A=B=63 P32", 2, 63, 63);
        t_ratio("R2 P64", 3, 10, 20);
        t_ratio("R4 A=0 P64", 3, 0, 40);
        t_ratio("R4 A=B P16", 1, 3, 3);
        t_ratio("R2 P8 again", 0, 5, 7);
        t_defer();
        t_ignore();
        t_err();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule